// File: doc/BRIEF.md
# DS1 Test Pattern Monitor

This block checks a serial DS1 test bit stream against a chosen test sequence and counts the bits that arrive wrong. The stream comes with its own receive clock. The block samples that clock in the system clock domain and takes one data bit on either its rising or its falling transition, as configuration selects. The received bit can be complemented before it is checked.

The checker works on a history of recent bits. For the pseudo-random sequences, the alternating sequence and the user-defined repeating word, it predicts each new bit from that history. While the checker is searching, the history fills with the received bits, so it locks onto the sequence by itself. Once in sync, the history fills with the predicted bits, so a single line error is counted exactly once. When framed operation is selected, a 193-bit position counter marks the framing bit of each frame. That bit is neither compared nor shifted into the history. A second counter tracks the frame number within a 12-frame or 24-frame superframe.

Errors are counted in a saturating counter only while the checker is in sync. A clear strobe zeroes the counter. Sync is declared after a run of error-free bits and dropped when too many errors fall in one observation window.

Top module: `ds1_patmon`

## Requirements
- R1: A data bit is taken on each rising transition of `rx_clk` when `cfg_rise` is 1, and on each falling transition when `cfg_rise` is 0. Transitions of the other polarity take no bit.
- R2: When `cfg_rx_inv` is 1, each taken bit is complemented before it is checked. A stream of ones checked against the all-ones code with inversion set never reaches sync.
- R3: `cfg_pattern` selects the expected sequence. Code 0 is x^15+x^14+1, code 1 is x^20+x^3+1, code 2 is x^20+x^17+1 (quasi-random, checked without zero suppression), code 3 is x^23+x^18+1, code 4 is alternating ones and zeros, code 5 is all ones, code 6 is unused and code 7 repeats a `USER_W`-bit word (default 24). For each pseudo-random code, the expected bit is the XOR of the two history bits named by the polynomial.
- R4: With `cfg_framed` at 1, the first bit after reset and every 193rd bit after it is a framing bit. Framing bits are never compared and never counted as errors.
- R5: `sf_mark` pulses for one cycle on the framing bit of frame 0 of each superframe. A superframe is 24 frames long when `cfg_esf` is 1 and 12 frames long when it is 0.
- R6: Out of sync, `in_sync` rises after 32 consecutive error-free compared bits, and not after 31.
- R7: In sync, `in_sync` falls on the 8th errored bit within one 64-bit window counted from sync entry. Fewer errors per window keep sync.
- R8: `err_flag` is high for one cycle for each compared bit that mismatches. `err_cnt` rises by one for each such bit while in sync, and does not change for errors out of sync.
- R9: `err_cnt` (`CNT_W` bits, default 16) saturates at all ones.
- R10: A `cnt_clr` pulse zeroes `err_cnt` on the next edge and leaves sync unchanged.
- R11: With the unused code 6, nothing is compared. `in_sync` and `err_flag` stay 0.
- R12: After reset `in_sync`, `err_flag`, `sf_mark` and `err_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_clk | input | 1 | Receive test clock, sampled by `clk` |
| rx_data | input | 1 | Receive test data |
| cfg_pattern | input | 3 | Expected sequence code |
| cfg_rx_inv | input | 1 | Complement received data |
| cfg_framed | input | 1 | Stream carries framing bits |
| cfg_esf | input | 1 | 24-frame superframe when 1, 12 when 0 |
| cfg_rise | input | 1 | Take bits on rising (1) or falling (0) transition |
| cnt_clr | input | 1 | Clear the error counter |
| in_sync | output | 1 | Checker is in sync |
| err_flag | output | 1 | Compared bit mismatched |
| err_cnt | output | CNT_W | Saturating in-sync error count |
| sf_mark | output | 1 | Superframe start pulse |

## Verification
The assertions check on every cycle the properties that concern only the counter and the flags. The count moves only by one, and only together with a mismatch flag. It saturates, and it obeys the clear. Sync is dropped only on a mismatch. The unused code keeps everything quiet, and a superframe mark never coincides with a mismatch. The bench scenarios show what needs a long, known stream: the exact 32-bit acquisition point, loss of sync on the eighth error in a window, self-locking on each sequence code, exclusion of framing bits, and the superframe period for both lengths. They also cover edge selection and inversion.

// File: rtl/ds1pm_pkg.sv
package ds1pm_pkg;
  typedef enum logic [2:0] {
    PAT_PN15  = 3'd0,
    PAT_PN20  = 3'd1,
    PAT_QRND  = 3'd2,
    PAT_PN23  = 3'd3,
    PAT_ALT   = 3'd4,
    PAT_ONES  = 3'd5,
    PAT_RSVD  = 3'd6,
    PAT_USER  = 3'd7
  } pat_e;

  localparam int PN_HIST_MIN = 23;
  localparam int FRAME_BITS  = 193;
  localparam int SF_SHORT    = 12;
  localparam int SF_LONG     = 24;
endpackage

// File: rtl/ds1pm_retime.sv
module ds1pm_retime (
  input  logic clk,
  input  logic rst,
  input  logic rx_clk,
  input  logic rx_data,
  input  logic rise_sel,
  output logic bit_stb,
  output logic bit_val
);
  logic ck_q, ck_d, dt_q;
  logic edge_hit;

  // edge detect on the sampled receive clock
  assign edge_hit = rise_sel ? (ck_q & ~ck_d) : (~ck_q & ck_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q    <= 1'b0;
      ck_d    <= 1'b0;
      dt_q    <= 1'b0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      ck_q    <= rx_clk;
      ck_d    <= ck_q;
      dt_q    <= rx_data;
      bit_stb <= edge_hit;
      bit_val <= dt_q;
    end
  end
endmodule

// File: rtl/ds1pm_framer.sv
module ds1pm_framer #(
  parameter int FRAME_LEN = 193,
  parameter int SF_SHORT  = 12,
  parameter int SF_LONG   = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic framed,
  input  logic esf,
  output logic fbit,
  output logic sf_first
);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam int FRM_W = $clog2(SF_LONG);

  logic [POS_W-1:0] pos;
  logic [FRM_W-1:0] frm;
  logic [FRM_W-1:0] frm_last;

  assign frm_last = esf ? FRM_W'(SF_LONG - 1) : FRM_W'(SF_SHORT - 1);
  assign fbit     = framed && (pos == '0);
  assign sf_first = fbit && (frm == '0);

  always_ff @(posedge clk) begin
    if (rst || !framed) begin
      pos <= '0;
      frm <= '0;
    end else if (stb) begin
      if (pos == POS_W'(FRAME_LEN - 1)) begin
        pos <= '0;
        frm <= (frm >= frm_last) ? '0 : frm + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ds1pm_check.sv
module ds1pm_check
  import ds1pm_pkg::*;
#(
  parameter int HIST_W = 24,
  parameter int USER_W = 24,
  parameter int RUN_N  = 32,
  parameter int WIN_N  = 64,
  parameter int LOSS_N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic skip,
  input  logic din,
  input  pat_e pat,
  output logic in_sync,
  output logic err_flag,
  output logic cnt_inc
);
  localparam int RUN_W  = $clog2(RUN_N);
  localparam int WIN_W  = $clog2(WIN_N);
  localparam int LOSS_W = $clog2(LOSS_N);

  logic [HIST_W-1:0] hist;
  logic [RUN_W-1:0]  run;
  logic [WIN_W-1:0]  wpos;
  logic [LOSS_W-1:0] werr;
  logic              cmp, expb, mism;

  always_comb begin
    unique case (pat)
      PAT_PN15: expb = hist[14] ^ hist[13];
      PAT_PN20: expb = hist[19] ^ hist[2];
      PAT_QRND: expb = hist[19] ^ hist[16];
      PAT_PN23: expb = hist[22] ^ hist[17];
      PAT_ALT:  expb = ~hist[0];
      PAT_ONES: expb = 1'b1;
      PAT_USER: expb = hist[USER_W-1];
      default:  expb = 1'b0;
    endcase
  end

  assign cmp     = stb && !skip && (pat != PAT_RSVD);
  assign mism    = din ^ expb;
  assign cnt_inc = cmp && mism && in_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      run      <= '0;
      wpos     <= '0;
      werr     <= '0;
      in_sync  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      err_flag <= cmp && mism;
      if (pat == PAT_RSVD) begin
        in_sync <= 1'b0;
        run     <= '0;
      end else if (cmp) begin
        hist <= {hist[HIST_W-2:0], in_sync ? expb : din};
        if (!in_sync) begin
          if (mism) begin
            run <= '0;
          end else if (run == RUN_W'(RUN_N - 1)) begin
            in_sync <= 1'b1;
            run     <= '0;
            wpos    <= '0;
            werr    <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else if (mism && (werr == LOSS_W'(LOSS_N - 1))) begin
          in_sync <= 1'b0;
          run     <= '0;
        end else begin
          wpos <= (wpos == WIN_W'(WIN_N - 1)) ? '0 : wpos + 1'b1;
          werr <= (wpos == WIN_W'(WIN_N - 1)) ? '0 : werr + LOSS_W'(mism);
        end
      end
    end
  end
endmodule

// File: rtl/ds1pm_errcnt.sv
module ds1pm_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ds1_patmon.sv
module ds1_patmon
  import ds1pm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int USER_W = 24,
  parameter int RUN_N  = 32,
  parameter int WIN_N  = 64,
  parameter int LOSS_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_clk,
  input  logic             rx_data,
  input  logic [2:0]       cfg_pattern,
  input  logic             cfg_rx_inv,
  input  logic             cfg_framed,
  input  logic             cfg_esf,
  input  logic             cfg_rise,
  input  logic             cnt_clr,
  output logic             in_sync,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_cnt,
  output logic             sf_mark
);
  localparam int HIST_W = (USER_W > PN_HIST_MIN) ? USER_W : PN_HIST_MIN;

  logic bit_stb, bit_val;
  logic fbit, sf_first, cnt_inc;

  ds1pm_retime u_retime (
    .clk      (clk),
    .rst      (rst),
    .rx_clk   (rx_clk),
    .rx_data  (rx_data),
    .rise_sel (cfg_rise),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val)
  );

  ds1pm_framer #(
    .FRAME_LEN (FRAME_BITS),
    .SF_SHORT  (SF_SHORT),
    .SF_LONG   (SF_LONG)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .stb      (bit_stb),
    .framed   (cfg_framed),
    .esf      (cfg_esf),
    .fbit     (fbit),
    .sf_first (sf_first)
  );

  ds1pm_check #(
    .HIST_W (HIST_W),
    .USER_W (USER_W),
    .RUN_N  (RUN_N),
    .WIN_N  (WIN_N),
    .LOSS_N (LOSS_N)
  ) u_check (
    .clk      (clk),
    .rst      (rst),
    .stb      (bit_stb),
    .skip     (fbit),
    .din      (bit_val ^ cfg_rx_inv),
    .pat      (pat_e'(cfg_pattern)),
    .in_sync  (in_sync),
    .err_flag (err_flag),
    .cnt_inc  (cnt_inc)
  );

  ds1pm_errcnt #(
    .CNT_W (CNT_W)
  ) u_errcnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (err_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) sf_mark <= 1'b0;
    else     sf_mark <= bit_stb && sf_first;
  end
endmodule

// File: rtl/ds1_patmon_chk.sv
module ds1_patmon_chk
  import ds1pm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cfg_pattern,
  input logic             cnt_clr,
  input logic             in_sync,
  input logic             err_flag,
  input logic [CNT_W-1:0] err_cnt,
  input logic             sf_mark
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_clr) && (err_cnt != $past(err_cnt))) |-> ((err_cnt == $past(err_cnt) + 1'b1) && err_flag)); // R8
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_clr) && ($past(err_cnt) == CMAX)) |-> (err_cnt == CMAX)); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_clr) |-> (err_cnt == '0)); // R10
  AST_LOSS_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
    ($fell(in_sync) && ($past(cfg_pattern) != 3'd6)) |-> err_flag); // R7
  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_pattern) == 3'd6) |-> (!in_sync && !err_flag)); // R11
  AST_FRAME_SKIP: assert property (@(posedge clk) disable iff (rst)
    sf_mark |-> !err_flag); // R4
endmodule

bind ds1_patmon ds1_patmon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_pattern (cfg_pattern),
  .cnt_clr     (cnt_clr),
  .in_sync     (in_sync),
  .err_flag    (err_flag),
  .err_cnt     (err_cnt),
  .sf_mark     (sf_mark)
);

// File: tb/ds1_patmon_bench.sv
`timescale 1ns/1ps
module ds1_patmon_bench;
  localparam int CNT_W = 4;
  localparam int HALF  = 2;
  localparam int NDATA = 600;
  localparam logic [23:0] UWORD = 24'hC3A55E;
  // {txinv, pat[2:0], framed, esf, inv, rise, nerr[1:0], sync, cnt[3:0]}
  localparam logic [14:0] VEC [0:8] = '{
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'd0},
    {1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'd2},
    {1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 4'd1},
    {1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 4'd3},
    {1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 4'd1},
    {1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'd2},
    {1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0},
    {1'b0, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_clk = 1'b0, rx_data = 1'b0;
  logic [2:0] cfg_pattern = 3'd0;
  logic cfg_rx_inv = 1'b0, cfg_framed = 1'b0, cfg_esf = 1'b0, cfg_rise = 1'b1;
  logic cnt_clr = 1'b0;
  logic in_sync, err_flag, sf_mark;
  logic [CNT_W-1:0] err_cnt;

  int checks = 0, errors = 0, marks = 0;
  bit done = 1'b0;
  logic [23:0] gh;
  int uidx;

  always #2 clk = ~clk;

  ds1_patmon #(.CNT_W(CNT_W)) u_ds1_patmon (
    .clk(clk), .rst(rst), .rx_clk(rx_clk), .rx_data(rx_data),
    .cfg_pattern(cfg_pattern), .cfg_rx_inv(cfg_rx_inv), .cfg_framed(cfg_framed),
    .cfg_esf(cfg_esf), .cfg_rise(cfg_rise), .cnt_clr(cnt_clr),
    .in_sync(in_sync), .err_flag(err_flag), .err_cnt(err_cnt), .sf_mark(sf_mark)
  );

  always @(negedge clk) if (!rst && sf_mark) marks++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_clk = ~cfg_rise;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    gh = 24'hFFFFFF;
    uidx = 0;
  endtask

  task automatic send_bit(input logic b);
    rx_data = b;
    rx_clk = ~cfg_rise;
    repeat (HALF) @(negedge clk);
    rx_clk = cfg_rise;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic gen_bit(output logic b);
    case (cfg_pattern)
      3'd0: b = gh[14] ^ gh[13];
      3'd1: b = gh[19] ^ gh[2];
      3'd2: b = gh[19] ^ gh[16];
      3'd3: b = gh[22] ^ gh[17];
      3'd4: b = ~gh[0];
      3'd7: begin b = UWORD[uidx]; uidx = (uidx == 23) ? 0 : uidx + 1; end
      default: b = 1'b1;
    endcase
    gh = {gh[22:0], b};
  endtask

  function automatic string vtag(input int v);
    case (v)
      1, 5:    return "R4";
      2, 8:    return "R2";
      3, 4:    return "R1";
      7:       return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic b;
    // R12 reset state
    do_reset();
    check(in_sync == 1'b0, "R12 in_sync", in_sync, 0);
    check(err_cnt == '0, "R12 err_cnt", err_cnt, 0);
    check(err_flag == 1'b0 && sf_mark == 1'b0, "R12 flags", {err_flag, sf_mark}, 0);

    // table of configurations, each ends with a sync and count check
    for (int v = 0; v < 9; v++) begin
      logic [14:0] e;
      int di, pos, nerr;
      logic fb, txinv;
      e = VEC[v];
      txinv       = e[14];
      cfg_pattern = e[13:11];
      cfg_framed  = e[10];
      cfg_esf     = e[9];
      cfg_rx_inv  = e[8];
      cfg_rise    = e[7];
      nerr        = int'(e[6:5]);
      do_reset();
      di = 0; pos = 0; fb = 1'b0;
      while (di < NDATA) begin
        if (cfg_framed && pos == 0) begin
          send_bit(fb);
          fb = ~fb;
        end else begin
          gen_bit(b);
          if ((nerr >= 1 && di == 300) || (nerr >= 2 && di == 350) || (nerr >= 3 && di == 400))
            b = ~b;
          send_bit(b ^ txinv);
          di++;
        end
        pos = (cfg_framed && pos != 192) ? pos + 1 : 0;
      end
      settle();
      check(in_sync == e[4], {vtag(v), " R6 sync"}, in_sync, e[4]);
      check(err_cnt == e[3:0], {vtag(v), " R8 count"}, err_cnt, e[3:0]);
    end

    // directed: exact acquisition and loss points, all-ones code
    cfg_pattern = 3'd5; cfg_framed = 1'b0; cfg_esf = 1'b0; cfg_rx_inv = 1'b0; cfg_rise = 1'b1;
    do_reset();
    for (int i = 0; i < 31; i++) send_bit(1'b1);
    settle();
    check(in_sync == 1'b0, "R6 after 31", in_sync, 0);
    send_bit(1'b1);
    settle();
    check(in_sync == 1'b1, "R6 after 32", in_sync, 1);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    settle();
    check(in_sync == 1'b1, "R7 seven errors", in_sync, 1);
    check(err_cnt == 4'd7, "R8 seven counted", err_cnt, 7);
    send_bit(1'b0);
    settle();
    check(in_sync == 1'b0, "R7 eighth error", in_sync, 0);
    check(err_cnt == 4'd8, "R8 eighth counted", err_cnt, 8);
    send_bit(1'b0); send_bit(1'b0);
    settle();
    check(err_cnt == 4'd8, "R8 out of sync ignored", err_cnt, 8);
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    settle();
    check(in_sync == 1'b1, "R6 reacquire", in_sync, 1);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    settle();
    check(err_cnt == '0, "R10 clear", err_cnt, 0);
    check(in_sync == 1'b1, "R10 sync kept", in_sync, 1);

    // saturation with sparse errors
    for (int k = 0; k < 18; k++) begin
      for (int i = 0; i < 19; i++) send_bit(1'b1);
      send_bit(1'b0);
    end
    settle();
    check(err_cnt == 4'hF, "R9 saturate", err_cnt, 15);
    check(in_sync == 1'b1, "R7 sparse errors keep sync", in_sync, 1);

    // superframe marks and framing-bit exclusion, 12 then 24 frames
    for (int m = 0; m < 2; m++) begin
      cfg_framed = 1'b1; cfg_esf = (m == 1);
      do_reset();
      marks = 0;
      for (int i = 0; i < 2317; i++) send_bit((i % 193) != 0);
      settle();
      check(marks == (m == 1 ? 1 : 2), "R5 superframe marks", marks, (m == 1 ? 1 : 2));
      check(err_cnt == '0, "R4 framing bits skipped", err_cnt, 0);
    end

    finish_run();
  end
endmodule